// File: doc/BRIEF.md
# Debug Cross-Trigger Router

This block passes debug trigger events between eight local trigger lines and four event channels shared with a channel matrix. A rising edge on a local trigger input is synchronised and turned into a one-cycle event. The event goes onto every channel selected for that input. Each local trigger output fires for one cycle when any channel selected for it carries an event. That event can come from this block or from the channel input.

Software sets the routing through a small word-addressed register port. Each trigger input has a 4-bit channel mask, and each bit enables one input-to-channel connection. Each trigger output has a 4-bit channel mask, and each bit enables one channel-to-output connection. One global enable bit gates all routing. Because the masks are independent, one input can reach many channels, many inputs can share one channel, and one channel can reach many outputs.

Top module: `xtrig_router`

## Requirements
- R1: After reset every mask register and the global enable read as zero, and `chan_out` and `trig_out` are zero.
- R2: The registers are decoded from the byte address `reg_addr` as follows. Address 0x00 + 4*i is the channel mask of trigger input i, with i from 0 to 7. Address 0x20 + 4*j is the channel mask of trigger output j, with j from 0 to 7. Address 0x40 is the global enable. A write stores `reg_wdata[3:0]` for a mask, and `reg_wdata[0]` for the enable, on the rising clock edge when `reg_we` is high. `reg_rdata` returns the stored value combinationally, with all other bits zero.
- R3: When trigger input i goes from low to high, `chan_out` equals its channel mask for exactly one cycle. Bit c of the mask selects channel c. This happens in the cycle after the second rising clock edge that samples the input high. An input that stays high raises no further event until it has gone low again.
- R4: `chan_out` is the bitwise OR of the channel masks of all inputs whose edges are detected in the same cycle. A mask bit of zero keeps that input off that channel.
- R5: Trigger output j goes high for one cycle, one cycle after any channel in its mask carries an event. A local input edge therefore reaches a mapped local output three clock edges after the input is first sampled high.
- R6: A one-cycle pulse on `chan_in[c]` raises every trigger output whose mask has bit c set, one cycle later. It never appears on `chan_out`.
- R7: While the global enable is zero, `chan_out` and `trig_out` stay zero for both local edges and `chan_in` events.
- R8: Writes to an unaligned address or to an unused aligned address change no register. Reads from such addresses return zero.
- R9: Events that arrive in the same cycle on the same channel merge into one event. This covers two local inputs, and also one local input together with `chan_in`. The result is a single one-cycle output pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_in | input | 8 | Local trigger inputs, asynchronous |
| trig_out | output | 8 | Local trigger outputs, registered one-cycle pulses |
| chan_in | input | 4 | Channel events from the matrix, synchronous pulses |
| chan_out | output | 4 | Locally generated channel events toward the matrix |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 7 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from `reg_addr` |

## Verification
The case of interest is a local edge and a channel-input event that reach the same channel in the same cycle, where both feed the output stage. The bench sets `chan_in` in exactly the cycle in which the local edge drives `chan_out`. The scoreboard expects a single one-cycle pulse on each mapped output, not a doubled or stretched one. The bench then shifts `chan_in` by one cycle and expects two back-to-back pulses. This shows that the two sources are merged and not held.

// File: rtl/xtrig_router.sv
module xtrig_router #(
  parameter int NTRIG = 8,
  parameter int NCHAN = 4,
  parameter int AW    = 7,
  parameter int DW    = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NTRIG-1:0] trig_in,
  output logic [NTRIG-1:0] trig_out,
  input  logic [NCHAN-1:0] chan_in,
  output logic [NCHAN-1:0] chan_out,
  input  logic             reg_we,
  input  logic [AW-1:0]    reg_addr,
  input  logic [DW-1:0]    reg_wdata,
  output logic [DW-1:0]    reg_rdata
);
  localparam int WIW     = AW - 2;
  localparam int OUT_IDX = NTRIG;
  localparam int CTL_IDX = 2 * NTRIG;

  logic [NTRIG-1:0][NCHAN-1:0] imask, omask;
  logic                        glob_en;
  logic [NTRIG-1:0]            s1, s2, s3, rise;
  logic [NCHAN-1:0]            local_ch, all_ch;
  logic [NTRIG-1:0]            trig_nxt;
  logic [WIW-1:0]              widx;
  logic                        aligned, wr_ok;
  logic                        unused_wdata;

  assign widx         = reg_addr[AW-1:2];
  assign aligned      = (reg_addr[1:0] == 2'b00);
  assign wr_ok        = reg_we && aligned;
  assign unused_wdata = ^reg_wdata[DW-1:NCHAN];

  for (genvar i = 0; i < NTRIG; i++) begin : g_cfg
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)
        imask[i] <= '0;
      else if (wr_ok && widx == WIW'(i))
        imask[i] <= reg_wdata[NCHAN-1:0];

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)
        omask[i] <= '0;
      else if (wr_ok && widx == WIW'(OUT_IDX + i))
        omask[i] <= reg_wdata[NCHAN-1:0];
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)
      glob_en <= 1'b0;
    else if (wr_ok && widx == WIW'(CTL_IDX))
      glob_en <= reg_wdata[0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1 <= '0;
      s2 <= '0;
      s3 <= '0;
    end else begin
      s1 <= trig_in;
      s2 <= s1;
      s3 <= s2;
    end

  assign rise = s2 & ~s3;

  always_comb begin
    local_ch = '0;
    for (int i = 0; i < NTRIG; i++)
      if (rise[i]) local_ch = local_ch | imask[i];
  end

  assign chan_out = glob_en ? local_ch : '0;
  assign all_ch   = chan_out | chan_in;

  always_comb
    for (int j = 0; j < NTRIG; j++)
      trig_nxt[j] = glob_en && ((omask[j] & all_ch) != '0);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) trig_out <= '0;
    else        trig_out <= trig_nxt;

  always_comb begin
    reg_rdata = '0;
    if (aligned) begin
      for (int i = 0; i < NTRIG; i++) begin
        if (widx == WIW'(i))           reg_rdata[NCHAN-1:0] = imask[i];
        if (widx == WIW'(OUT_IDX + i)) reg_rdata[NCHAN-1:0] = omask[i];
      end
      if (widx == WIW'(CTL_IDX)) reg_rdata[0] = glob_en;
    end
  end
endmodule

// File: rtl/xtrig_router_chk.sv
module xtrig_router_chk #(
  parameter int NTRIG = 8,
  parameter int NCHAN = 4
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic [NCHAN-1:0]            chan_in,
  input logic [NCHAN-1:0]            chan_out,
  input logic [NTRIG-1:0]            trig_out,
  input logic                        en,
  input logic [NTRIG-1:0][NCHAN-1:0] omask
);
  a_r1_clean_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (trig_out == '0 && chan_out == '0 && !en));

  a_r7_off_no_out: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> trig_out == '0);

  a_r3_chan_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
    chan_out != '0 |-> en);

  for (genvar j = 0; j < NTRIG; j++) begin : g_out
    a_r6_ext_reaches: assert property (@(posedge clk) disable iff (!rst_n)
      (en && (chan_in & omask[j]) != '0) |=> trig_out[j]);

    a_r5_out_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
      trig_out[j] |-> $past(en && ((chan_out | chan_in) & omask[j]) != '0));
  end
endmodule

bind xtrig_router xtrig_router_chk #(.NTRIG(NTRIG), .NCHAN(NCHAN)) u_chk (
  .clk(clk), .rst_n(rst_n), .chan_in(chan_in), .chan_out(chan_out),
  .trig_out(trig_out), .en(glob_en), .omask(omask)
);

// File: tb/xtrig_router_test.sv
module xtrig_router_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  trig_in = '0;
  logic [7:0]  trig_out;
  logic [3:0]  chan_in = '0;
  logic [3:0]  chan_out;
  logic        reg_we = 1'b0;
  logic [6:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;

  xtrig_router uut (
    .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .trig_out(trig_out),
    .chan_in(chan_in), .chan_out(chan_out), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  always #4 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;
  bit mon_on = 0, done = 0;
  string ph = "R1";
  int q_cyc[$];
  logic [3:0] q_ch[$];
  logic [7:0] q_tr[$];
  string q_tag[$];
  logic [3:0] im [8];
  logic [3:0] om [8];
  logic gen = 0;
  logic [3:0] ech;
  logic [7:0] etr;
  string tg;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [7:0] model_tr(logic [3:0] ch);
    logic [7:0] t = '0;
    for (int j = 0; j < 8; j++) t[j] = gen && ((om[j] & ch) != 0);
    return t;
  endfunction

  task automatic push(int c, logic [3:0] ch, logic [7:0] tr, string tag);
    q_cyc.push_back(c); q_ch.push_back(ch); q_tr.push_back(tr); q_tag.push_back(tag);
  endtask

  initial forever begin
    @(negedge clk);
    if (mon_on) begin
      ech = '0; etr = '0; tg = ph;
      for (int k = q_cyc.size() - 1; k >= 0; k--)
        if (q_cyc[k] == cyc) begin
          ech |= q_ch[k]; etr |= q_tr[k]; tg = q_tag[k];
          q_cyc.delete(k); q_ch.delete(k); q_tr.delete(k); q_tag.delete(k);
        end
      checks++;
      if (chan_out !== ech || trig_out !== etr) begin
        errors++;
        $display("FAIL %s cyc %0d: chan_out=%h trig_out=%h expected chan_out=%h trig_out=%h",
                 tg, cyc, chan_out, trig_out, ech, etr);
      end
    end
  end

  task automatic wr(logic [6:0] a, logic [31:0] d);
    @(negedge clk);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 0;
    if (a[1:0] == 0) begin
      if (a < 7'h20)       im[a >> 2] = d[3:0];
      else if (a < 7'h40)  om[(a - 7'h20) >> 2] = d[3:0];
      else if (a == 7'h40) gen = d[0];
    end
  endtask

  task automatic rd_chk(logic [6:0] a, logic [31:0] exp, string tag);
    @(negedge clk);
    reg_addr = a;
    #1;
    checks++;
    if (reg_rdata !== exp) begin
      errors++;
      $display("FAIL %s read %h: got %h expected %h", tag, a, reg_rdata, exp);
    end
  endtask

  task automatic fire(logic [7:0] v, string tag);
    logic [3:0] ch = '0;
    @(negedge clk);
    trig_in = v;
    for (int i = 0; i < 8; i++) if (v[i]) ch |= im[i];
    if (!gen) ch = '0;
    push(cyc + 2, ch, 8'h00, tag);
    push(cyc + 3, 4'h0, model_tr(ch), tag);
    @(negedge clk);
    trig_in = '0;
  endtask

  task automatic ext(logic [3:0] v, string tag);
    @(negedge clk);
    chan_in = v;
    push(cyc + 1, 4'h0, model_tr(v), tag);
    @(negedge clk);
    chan_in = '0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 8; i++) begin im[i] = '0; om[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    mon_on = 1;
    ph = "R1";
    for (int a = 0; a <= 'h40; a += 4) rd_chk(7'(a), 32'h0, "R1");

    ph = "R2";
    wr(7'h14, 32'hFFFF_FFFF);
    rd_chk(7'h14, 32'h0000_000F, "R2");
    wr(7'h3C, 32'h0000_0005);
    rd_chk(7'h3C, 32'h0000_0005, "R2");
    wr(7'h40, 32'hFFFF_FFFE);
    rd_chk(7'h40, 32'h0, "R2");

    ph = "R8";
    wr(7'h44, 32'hF);
    rd_chk(7'h44, 32'h0, "R8");
    wr(7'h15, 32'h3);
    rd_chk(7'h14, 32'hF, "R8");
    rd_chk(7'h15, 32'h0, "R8");

    ph = "R7";
    wr(7'h00, 32'h8);
    wr(7'h2C, 32'h8);
    wr(7'h3C, 32'h8);
    wr(7'h24, 32'h4);
    fire(8'h01, "R7");
    idle(5);
    ext(4'hF, "R7");
    idle(3);

    ph = "R3";
    wr(7'h40, 32'h1);
    rd_chk(7'h40, 32'h1, "R2");
    fire(8'h01, "R3");
    idle(5);

    ph = "R4";
    wr(7'h04, 32'h1);
    wr(7'h08, 32'h3);
    wr(7'h20, 32'h1);
    fire(8'h06, "R4");
    idle(5);
    wr(7'h08, 32'h0);
    fire(8'h04, "R4");
    idle(5);

    ph = "R3";
    wr(7'h10, 32'h6);
    wr(7'h30, 32'h2);
    @(negedge clk);
    trig_in = 8'h10;
    push(cyc + 2, 4'h6, 8'h00, "R3");
    push(cyc + 3, 4'h0, model_tr(4'h6), "R3");
    idle(10);
    trig_in = 8'h00;
    idle(5);

    ph = "R6";
    ext(4'h4, "R6");
    idle(3);
    ext(4'h2, "R6");
    idle(3);

    ph = "R5";
    fire(8'h11, "R5");
    idle(5);

    ph = "R9";
    @(negedge clk);
    trig_in = 8'h01;
    push(cyc + 2, 4'h8, 8'h00, "R9");
    push(cyc + 3, 4'h0, model_tr(4'h8), "R9");
    @(negedge clk);
    trig_in = 8'h00;
    @(negedge clk);
    chan_in = 4'h8;
    push(cyc + 1, 4'h0, model_tr(4'h8), "R9");
    @(negedge clk);
    chan_in = 4'h0;
    idle(5);
    @(negedge clk);
    trig_in = 8'h01;
    push(cyc + 2, 4'h8, 8'h00, "R9");
    push(cyc + 3, 4'h0, model_tr(4'h8), "R9");
    @(negedge clk);
    trig_in = 8'h00;
    @(negedge clk);
    @(negedge clk);
    chan_in = 4'h8;
    push(cyc + 1, 4'h0, model_tr(4'h8), "R9");
    @(negedge clk);
    chan_in = 4'h0;
    idle(5);

    mon_on = 0;
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule